// File: doc/BRIEF.md
# Privileged Access-Override Flag Instruction Unit

This block executes the pair of three-byte instructions that raise and drop the access-override bit of a processor flags word. The kernel raises the bit just before it deliberately touches user memory and drops it straight afterwards, so that any stray user access made outside such a window still faults. The unit holds the whole flags word but only ever alters the override bit by instruction. A separate word-write port lets surrounding logic restore the complete flags word, for example on return from an exception.

Each cycle the unit looks at one instruction byte triple qualified by a valid strobe. When the triple is one of the two encodings, the outcome depends on a feature-present strap and the current privilege level. The instruction may complete and update the bit. It may raise an undefined-opcode exception. It may raise a privilege exception. Any other triple is left to other decode logic and produces no response here. The operating mode of the processor plays no part, so there is no mode input.

Top module: `ovrf_unit`

## Requirements
- R1: With `insn_valid` high, bytes `insn_b0`=0x0F, `insn_b1`=0x01, `insn_b2`=0xCB, `feat_present`=1 and `cur_priv`=0, bit 18 of `flags_out` is 1 after the next clock edge and `done_pulse` is high for that one cycle.
- R2: The same conditions with `insn_b2`=0xCA make bit 18 of `flags_out` 0 after the next clock edge, with a one-cycle `done_pulse`.
- R3: Either encoding with `feat_present`=0 gives a one-cycle `ud_pulse` after the next edge and leaves `flags_out` unchanged. This holds at every privilege level, because the missing feature is checked before privilege.
- R4: Either encoding with `feat_present`=1 and `cur_priv` not 0 gives a one-cycle `priv_pulse` and leaves `flags_out` unchanged.
- R5: A completing instruction leaves every flags bit other than bit 18 at its previous value.
- R6: A triple that matches neither encoding, or any triple with `insn_valid` low, gives no pulse on any of the three pulse outputs and does not change `flags_out`.
- R7: With `fw_valid` high and no completing instruction in the same cycle, `flags_out` equals `fw_data` after the next edge. An instruction that faults or is not recognised does not block the write.
- R8: When `fw_valid` is high in the same cycle as a completing instruction, the word write is dropped. The result is the previous flags word with only bit 18 changed by the instruction.
- R9: A clock edge with `rst_n` low sets `flags_out` to all zeros, so bit 18 starts at 0 and prevention starts active. The same edge clears all three pulses.
- R10: At most one of `done_pulse`, `ud_pulse` and `priv_pulse` is high in any cycle. Instructions presented on consecutive cycles each produce their own pulse, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_valid | input | 1 | Byte triple is valid this cycle |
| insn_b0 | input | 8 | First instruction byte |
| insn_b1 | input | 8 | Second instruction byte |
| insn_b2 | input | 8 | Third instruction byte, selects raise or drop |
| cur_priv | input | 2 | Current privilege level, 0 is most privileged |
| feat_present | input | 1 | Strap: the override feature is implemented |
| fw_valid | input | 1 | Whole flags-word write strobe |
| fw_data | input | 32 | Flags word to write |
| flags_out | output | 32 | Current flags word, override at bit 18 |
| done_pulse | output | 1 | Instruction completed |
| ud_pulse | output | 1 | Undefined-opcode exception |
| priv_pulse | output | 1 | Privilege exception |

## Verification
Every result of this unit is due exactly one clock edge after the cycle in which its stimulus is presented. This covers the flags update, each of the three pulses, a word write and a reset. The bench drives a stimulus at a falling edge and updates its reference model at the following rising edge from the inputs still held. At the next falling edge it compares the flags word and all three pulses. Sampling halfway between edges keeps each check on the cycle the result is due and away from the edge where it changes.

// File: rtl/ovrf_pkg.sv
// Package: shared encodings for the access-override flag instruction unit.
// Assumes: three-byte encodings with a shared two-byte prefix.
package ovrf_pkg;
    localparam logic [7:0] ESC_BYTE = 8'h0F;
    localparam logic [7:0] GRP_BYTE = 8'h01;
    localparam logic [7:0] RAISE_BYTE = 8'hCB;
    localparam logic [7:0] DROP_BYTE = 8'hCA;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_RAISE = 2'd1,
        OP_DROP  = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        VD_PASS = 2'd0,
        VD_DONE = 2'd1,
        VD_UD   = 2'd2,
        VD_PRIV = 2'd3
    } verdict_e;
endpackage

// File: rtl/ovrf_decode.sv
// Module: ovrf_decode
// Recognises the raise and drop encodings in a qualified byte triple.
// Assumes: the bytes are stable while valid is high. The result is purely combinational.
module ovrf_decode
    import ovrf_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned N_PREFIX = 2
) (
    input  logic              valid,
    input  logic [BYTE_W-1:0] b0,
    input  logic [BYTE_W-1:0] b1,
    input  logic [BYTE_W-1:0] b2,
    output op_e               op
);
    localparam int unsigned PFX_LAST = N_PREFIX - 1;

    logic [BYTE_W-1:0] prefix_bytes [N_PREFIX];
    logic [BYTE_W-1:0] prefix_code  [N_PREFIX];
    logic [PFX_LAST:0] prefix_hit;

    assign prefix_bytes[0] = b0;
    assign prefix_bytes[1] = b1;
    assign prefix_code[0]  = BYTE_W'(ESC_BYTE);
    assign prefix_code[1]  = BYTE_W'(GRP_BYTE);

    // Compare each prefix byte with its expected code.
    genvar gi;
    generate
        for (gi = 0; gi < N_PREFIX; gi++) begin : g_pfx
            assign prefix_hit[gi] = (prefix_bytes[gi] == prefix_code[gi]);
        end
    endgenerate

    // Select the operation from the final byte once the prefix matches.
    always_comb begin
        op = OP_NONE;
        if (valid && (&prefix_hit)) begin
            if (b2 == BYTE_W'(RAISE_BYTE))     op = OP_RAISE;
            else if (b2 == BYTE_W'(DROP_BYTE)) op = OP_DROP;
        end
    end
endmodule

// File: rtl/ovrf_gate.sv
// Module: ovrf_gate
// Decides whether a decoded instruction completes, is undefined, or is refused for privilege.
// Assumes: a missing feature outranks the privilege check. No mode input takes part.
module ovrf_gate
    import ovrf_pkg::*;
#(
    parameter int unsigned PRIV_W = 2,
    parameter int unsigned KERNEL_LVL = 0
) (
    input  op_e               op,
    input  logic [PRIV_W-1:0] cur_priv,
    input  logic              feat_present,
    output verdict_e          verdict,
    output logic              new_bit
);
    localparam logic [PRIV_W-1:0] KLVL = PRIV_W'(KERNEL_LVL);

    // Rank the outcomes: feature first, then privilege, then completion.
    always_comb begin
        verdict = VD_PASS;
        if (op != OP_NONE) begin
            if (!feat_present)          verdict = VD_UD;
            else if (cur_priv != KLVL)  verdict = VD_PRIV;
            else                        verdict = VD_DONE;
        end
    end

    // The override value is 1 for the raise encoding and 0 for the drop encoding.
    assign new_bit = (op == OP_RAISE);
endmodule

// File: rtl/ovrf_flagreg.sv
// Module: ovrf_flagreg
// Holds the flags word and registers the three outcome pulses.
// Assumes: a completing instruction outranks the whole-word write, and only the override bit moves.
module ovrf_flagreg
    import ovrf_pkg::*;
#(
    parameter int unsigned FLAGS_W = 32,
    parameter int unsigned OVR_BIT = 18,
    parameter logic [FLAGS_W-1:0] RESET_FLAGS = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  verdict_e           verdict,
    input  logic               new_bit,
    input  logic               fw_valid,
    input  logic [FLAGS_W-1:0] fw_data,
    output logic [FLAGS_W-1:0] flags,
    output logic               done_pulse,
    output logic               ud_pulse,
    output logic               priv_pulse
);
    localparam logic [FLAGS_W-1:0] OVR_MASK = FLAGS_W'(1) << OVR_BIT;
    localparam logic [FLAGS_W-1:0] RST_VAL  = RESET_FLAGS & ~OVR_MASK;
    localparam logic [FLAGS_W-1:0] KEEP_MASK = ~OVR_MASK;

    logic [FLAGS_W-1:0] flags_q;
    logic done_q, ud_q, priv_q;

    // Update the flags word: reset, then instruction, then word write.
    always_ff @(posedge clk) begin
        if (!rst_n)                  flags_q <= RST_VAL;
        else if (verdict == VD_DONE) flags_q[OVR_BIT] <= new_bit;
        else if (fw_valid)           flags_q <= fw_data;
    end

    // Register one pulse per outcome for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            ud_q   <= 1'b0;
            priv_q <= 1'b0;
        end else begin
            done_q <= (verdict == VD_DONE);
            ud_q   <= (verdict == VD_UD);
            priv_q <= (verdict == VD_PRIV);
        end
    end

    assign flags      = flags_q;
    assign done_pulse = done_q;
    assign ud_pulse   = ud_q;
    assign priv_pulse = priv_q;

    assert_one_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_q, ud_q, priv_q}))
        else $error("more than one outcome pulse");

    assert_keep_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict == VD_DONE) |=> ((flags_q & KEEP_MASK) == ($past(flags_q) & KEEP_MASK)))
        else $error("completing instruction touched other bits");

    assert_word_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_valid && verdict != VD_DONE) |=> (flags_q == $past(fw_data)))
        else $error("word write not applied");

    assert_fault_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((verdict == VD_PRIV || verdict == VD_UD) && !fw_valid) |=> $stable(flags_q))
        else $error("faulting instruction changed flags");
endmodule

// File: rtl/ovrf_unit.sv
// Module: ovrf_unit (top)
// Executes the raise and drop access-override instructions against a flags word.
// Assumes: one triple per cycle, results one edge later, synchronous active-low reset.
module ovrf_unit
    import ovrf_pkg::*;
#(
    parameter int unsigned FLAGS_W = 32,
    parameter int unsigned OVR_BIT = 18,
    parameter int unsigned PRIV_W = 2,
    parameter int unsigned KERNEL_LVL = 0,
    parameter logic [FLAGS_W-1:0] RESET_FLAGS = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               insn_valid,
    input  logic [7:0]         insn_b0,
    input  logic [7:0]         insn_b1,
    input  logic [7:0]         insn_b2,
    input  logic [PRIV_W-1:0]  cur_priv,
    input  logic               feat_present,
    input  logic               fw_valid,
    input  logic [FLAGS_W-1:0] fw_data,
    output logic [FLAGS_W-1:0] flags_out,
    output logic               done_pulse,
    output logic               ud_pulse,
    output logic               priv_pulse
);
    op_e      dec_op;
    verdict_e gate_vd;
    logic     gate_bit;

    ovrf_decode #(.BYTE_W(8), .N_PREFIX(2)) u_decode (
        .valid (insn_valid),
        .b0    (insn_b0),
        .b1    (insn_b1),
        .b2    (insn_b2),
        .op    (dec_op)
    );

    ovrf_gate #(.PRIV_W(PRIV_W), .KERNEL_LVL(KERNEL_LVL)) u_gate (
        .op           (dec_op),
        .cur_priv     (cur_priv),
        .feat_present (feat_present),
        .verdict      (gate_vd),
        .new_bit      (gate_bit)
    );

    ovrf_flagreg #(.FLAGS_W(FLAGS_W), .OVR_BIT(OVR_BIT), .RESET_FLAGS(RESET_FLAGS)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .verdict    (gate_vd),
        .new_bit    (gate_bit),
        .fw_valid   (fw_valid),
        .fw_data    (fw_data),
        .flags      (flags_out),
        .done_pulse (done_pulse),
        .ud_pulse   (ud_pulse),
        .priv_pulse (priv_pulse)
    );

    logic pfx_ok, is_raise, is_drop, kern;
    assign pfx_ok   = insn_valid && (insn_b0 == 8'h0F) && (insn_b1 == 8'h01);
    assign is_raise = pfx_ok && (insn_b2 == 8'hCB);
    assign is_drop  = pfx_ok && (insn_b2 == 8'hCA);
    assign kern     = (cur_priv == PRIV_W'(KERNEL_LVL));

    assert_raise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (is_raise && feat_present && kern) |=> (flags_out[OVR_BIT] && done_pulse))
        else $error("raise did not complete");

    assert_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_drop && feat_present && kern) |=> (!flags_out[OVR_BIT] && done_pulse))
        else $error("drop did not complete");

    assert_undef_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((is_raise || is_drop) && !feat_present && !fw_valid) |=> (ud_pulse && $stable(flags_out)))
        else $error("missing feature not reported");

    assert_priv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((is_raise || is_drop) && feat_present && !kern) |=> (priv_pulse && !done_pulse))
        else $error("privilege fault not reported");

    assert_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_raise && !is_drop && !fw_valid) |=> (!done_pulse && !ud_pulse && !priv_pulse && $stable(flags_out)))
        else $error("unrecognised triple had an effect");

    assert_write_lose_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((is_raise || is_drop) && feat_present && kern && fw_valid) |=>
            ((flags_out & ~(FLAGS_W'(1) << OVR_BIT)) == ($past(flags_out) & ~(FLAGS_W'(1) << OVR_BIT))))
        else $error("word write not dropped under instruction");
endmodule

// File: tb/ovrf_unit_tb.sv
// Bench: drives triples at falling edges, advances a behavioural model at each
// rising edge, and compares every output at the following falling edge.
module ovrf_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [7:0]  insn_b0 = '0, insn_b1 = '0, insn_b2 = '0;
    logic [1:0]  cur_priv = '0;
    logic        feat_present = 1'b1;
    logic        fw_valid = 1'b0;
    logic [31:0] fw_data = '0;
    logic [31:0] flags_out;
    logic        done_pulse, ud_pulse, priv_pulse;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [31:0] m_flags = '0;
    logic m_done = 0, m_ud = 0, m_priv = 0;

    always #4 clk = ~clk;

    ovrf_unit u_dut (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid),
        .insn_b0(insn_b0), .insn_b1(insn_b1), .insn_b2(insn_b2),
        .cur_priv(cur_priv), .feat_present(feat_present),
        .fw_valid(fw_valid), .fw_data(fw_data), .flags_out(flags_out),
        .done_pulse(done_pulse), .ud_pulse(ud_pulse), .priv_pulse(priv_pulse)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Advance the reference model one edge from the inputs currently held.
    task automatic model_edge();
        bit known, hit_raise;
        logic [31:0] nxt;
        known = insn_valid && insn_b0 == 8'h0F && insn_b1 == 8'h01 &&
                (insn_b2 == 8'hCB || insn_b2 == 8'hCA);
        hit_raise = (insn_b2 == 8'hCB);
        if (!rst_n) begin
            m_flags = '0; m_done = 0; m_ud = 0; m_priv = 0;
        end else begin
            m_done = 0; m_ud = 0; m_priv = 0;
            if (known) begin
                if (!feat_present)       m_ud = 1;
                else if (cur_priv != 0)  m_priv = 1;
                else                     m_done = 1;
            end
            nxt = m_flags;
            if (m_done)        nxt[18] = hit_raise;
            else if (fw_valid) nxt = fw_data;
            m_flags = nxt;
        end
    endtask

    // Present one cycle of stimulus, then compare all outputs against the model.
    task automatic step(input string tag, input logic v, input logic [7:0] a, input logic [7:0] b,
                        input logic [7:0] c, input logic [1:0] p, input logic f,
                        input logic wv, input logic [31:0] wd);
        insn_valid = v; insn_b0 = a; insn_b1 = b; insn_b2 = c;
        cur_priv = p; feat_present = f; fw_valid = wv; fw_data = wd;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag, "flags", flags_out, m_flags);
        check(tag, "done", 32'(done_pulse), 32'(m_done));
        check(tag, "ud", 32'(ud_pulse), 32'(m_ud));
        check(tag, "priv", 32'(priv_pulse), 32'(m_priv));
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 8'h00, 8'h00, 8'h00, 2'd0, 1, 0, 32'h0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        @(negedge clk);
        // R9: reset with garbage on the inputs
        rst_n = 0;
        step("R9", 1, 8'h0F, 8'h01, 8'hCB, 2'd0, 1, 1, 32'hFFFF_FFFF);
        step("R9", 0, 8'h00, 8'h00, 8'h00, 2'd0, 1, 0, 32'h0);
        rst_n = 1;
        idle("R9");
        // R7: whole-word load with override bit clear
        step("R7", 0, 8'h00, 8'h00, 8'h00, 2'd0, 1, 1, 32'hA5A1_0F0F);
        // R1 and R5: raise keeps the other bits
        step("R1", 1, 8'h0F, 8'h01, 8'hCB, 2'd0, 1, 0, 32'h0);
        idle("R5");
        // R2 and R5: drop keeps the other bits
        step("R2", 1, 8'h0F, 8'h01, 8'hCA, 2'd0, 1, 0, 32'h0);
        idle("R5");
        // R3: feature missing, both encodings and a non-kernel level
        step("R3", 1, 8'h0F, 8'h01, 8'hCB, 2'd0, 0, 0, 32'h0);
        step("R1", 1, 8'h0F, 8'h01, 8'hCB, 2'd0, 1, 0, 32'h0);
        step("R3", 1, 8'h0F, 8'h01, 8'hCA, 2'd0, 0, 0, 32'h0);
        step("R3", 1, 8'h0F, 8'h01, 8'hCA, 2'd3, 0, 0, 32'h0);
        // R4: privilege faults at levels 3 and 1
        step("R4", 1, 8'h0F, 8'h01, 8'hCA, 2'd3, 1, 0, 32'h0);
        step("R4", 1, 8'h0F, 8'h01, 8'hCA, 2'd1, 1, 0, 32'h0);
        step("R2", 1, 8'h0F, 8'h01, 8'hCA, 2'd0, 1, 0, 32'h0);
        step("R4", 1, 8'h0F, 8'h01, 8'hCB, 2'd2, 1, 0, 32'h0);
        // R6: near-miss triples and a valid-low triple
        step("R6", 1, 8'h0F, 8'h01, 8'hCC, 2'd0, 1, 0, 32'h0);
        step("R6", 1, 8'h0E, 8'h01, 8'hCB, 2'd0, 1, 0, 32'h0);
        step("R6", 1, 8'h0F, 8'h00, 8'hCB, 2'd0, 1, 0, 32'h0);
        step("R6", 0, 8'h0F, 8'h01, 8'hCB, 2'd0, 1, 0, 32'h0);
        // R8: word write dropped under a completing raise
        step("R8", 1, 8'h0F, 8'h01, 8'hCB, 2'd0, 1, 1, 32'h0000_1234);
        idle("R8");
        // R7: word write still applies beside a faulting or unknown triple
        step("R7", 1, 8'h0F, 8'h01, 8'hCA, 2'd3, 1, 1, 32'h1234_5678);
        step("R7", 1, 8'h0F, 8'h01, 8'hCB, 2'd0, 0, 1, 32'h0004_0001);
        step("R7", 1, 8'h0F, 8'h01, 8'h99, 2'd0, 1, 1, 32'hDEAD_BEEF);
        // R10: back-to-back instructions, one pulse each cycle
        step("R10", 1, 8'h0F, 8'h01, 8'hCA, 2'd0, 1, 0, 32'h0);
        step("R10", 1, 8'h0F, 8'h01, 8'hCB, 2'd0, 1, 0, 32'h0);
        step("R10", 1, 8'h0F, 8'h01, 8'hCA, 2'd0, 1, 0, 32'h0);
        step("R10", 1, 8'h0F, 8'h01, 8'hCB, 2'd1, 1, 0, 32'h0);
        step("R10", 1, 8'h0F, 8'h01, 8'hCB, 2'd0, 0, 0, 32'h0);
        step("R10", 1, 8'h0F, 8'h01, 8'hCB, 2'd0, 1, 0, 32'h0);
        // R9: reset mid-run with the override bit set
        rst_n = 0;
        step("R9", 1, 8'h0F, 8'h01, 8'hCB, 2'd0, 1, 0, 32'h0);
        rst_n = 1;
        idle("R9");
        finish_run();
    end
endmodule